// File: doc/BRIEF.md
# Converter Output Frame Assembler

This block builds the serial result frame of an analog-to-digital converter and shifts it out. A sample field comes first. It carries either the parallel conversion result or one of four fixed test patterns. Optional fields may follow it: a 4-bit device address, the supply alarm flags, the input alarm flags and a 4-bit range code. When parity is enabled, two even-parity bits close the frame. Which fields appear, and so how long the frame is, is set by a 32-bit control word. Software reaches that word one byte at a time at addresses 10h to 13h.

A one-cycle start pulse captures the sample, the side-band values and the configuration into a frame register. After that, each cycle with the shift enable high puts the next bit on the serial line, most significant bit first. One further enable after the last bit ends the frame and raises a one-cycle done pulse. The serial line is held low while the block is idle.

Top module: `adc_frame_tx`

## Requirements
- R1: When control bit 2 is 0, the sample field (SAMPLE_W bits, MSB first) carries the conversion result captured at the start pulse. The values of control bits 1:0 make no difference in this case.
- R2: Control bits 2:0 select a test pattern in place of the sample. Code 100 gives all zeros and 101 gives all ones. Code 110 gives single bits alternating, with 0 at the MSB (0x5555 at width 16). Code 111 gives pairs alternating, with 00 at the MSB (0x3333 at width 16).
- R3: Control bit 14 set appends the 4-bit device address, MSB first, directly after the sample field.
- R4: Control bits 13:12 select supply flags after the device address: 00 appends none, 01 the high flag, 10 the low flag, 11 both with high first.
- R5: Control bits 11:10 select input flags after the supply flags, with the same encoding as R4, using the input high and low flags.
- R6: Control bit 8 set appends the 4-bit range code after the input flags.
- R7: Control bit 3 set appends two final bits. The first is the even parity of the sample field alone. The second is the even parity of every earlier frame bit, the first parity bit not counted.
- R8: The control word resets to zero. Byte k sits at address 10h+k. Bits 31:15, 9 and 7:4 read back as 0 whatever is written. Writes to other addresses change nothing, and a read of another address returns 0.
- R9: Frame contents and length are fixed when the start pulse is taken. A register write during a frame affects only the next frame. A start pulse while busy is ignored.
- R10: Busy rises the cycle after start. Each shift-enable cycle presents the next bit on the serial line. The enable after the last bit drives the line low, drops busy and pulses done for one cycle. The line is low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Byte write strobe for the control word |
| reg_addr | input | 8 | Byte address (10h to 13h map the control word) |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for reg_addr (combinational) |
| sample | input | SAMPLE_W | Parallel conversion result |
| dev_addr | input | 4 | Device address value |
| range_code | input | 4 | Input range setting |
| sup_hi_flag | input | 1 | Active supply high alarm |
| sup_lo_flag | input | 1 | Active supply low alarm |
| in_hi_flag | input | 1 | Active input high alarm |
| in_lo_flag | input | 1 | Active input low alarm |
| start | input | 1 | Capture inputs and begin a frame |
| shift_en | input | 1 | Bit-rate enable |
| sdo | output | 1 | Serial frame data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
A start pulse is registered on the next clock edge, and busy is high from that edge on. Frame bit i appears on sdo at the edge of the (i+1)-th enable cycle after the start. Done, low sdo and low busy all appear at the edge of the enable that follows the last bit. The bench drives inputs on falling edges and samples at the next falling edge, so every value is read half a period after the edge that produced it. Register reads are combinational and are sampled shortly after the address settles. The sweeps cover all eight data-select codes and every combination of optional fields. A gapped-enable frame checks that sdo holds its bit between enables.

// File: rtl/afx_pkg.sv
package afx_pkg;

    // Control word field positions
    localparam int unsigned CW_VAL_LSB  = 0;
    localparam int unsigned CW_PAR_BIT  = 3;
    localparam int unsigned CW_RNG_BIT  = 8;
    localparam int unsigned CW_IN_LSB   = 10;
    localparam int unsigned CW_SUP_LSB  = 12;
    localparam int unsigned CW_DEV_BIT  = 14;

    localparam logic [31:0] CW_WR_MASK  = 32'h0000_7D0F;
    localparam int unsigned CW_BYTES    = 4;

    // Data value select codes
    localparam logic [2:0] VAL_ZEROS = 3'b100;
    localparam logic [2:0] VAL_ONES  = 3'b101;
    localparam logic [2:0] VAL_ALT1  = 3'b110;
    localparam logic [2:0] VAL_ALT2  = 3'b111;

    typedef struct packed {
        logic       dev_inc;
        logic [1:0] sup_sel;
        logic [1:0] in_sel;
        logic       rng_inc;
        logic       par_en;
        logic [2:0] val_sel;
    } frame_cfg_t;

    localparam int unsigned OPT_BITS = 4 + 2 + 2 + 4 + 2;

endpackage

// File: rtl/afx_ctrl_regs.sv
module afx_ctrl_regs
    import afx_pkg::*;
#(
    parameter int unsigned      ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output frame_cfg_t        cfg_o
);

    typedef struct packed {
        logic [31:0] word;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d  = regs_q;
        rdata_o = '0;
        for (int b = 0; b < int'(CW_BYTES); b++) begin
            if (addr_i == BASE_ADDR + ADDR_W'(b)) begin
                rdata_o = regs_q.word[8*b +: 8];
                if (wr_en_i) begin
                    regs_d.word[8*b +: 8] = wdata_i & CW_WR_MASK[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        cfg_o.dev_inc = regs_q.word[CW_DEV_BIT];
        cfg_o.sup_sel = regs_q.word[CW_SUP_LSB +: 2];
        cfg_o.in_sel  = regs_q.word[CW_IN_LSB +: 2];
        cfg_o.rng_inc = regs_q.word[CW_RNG_BIT];
        cfg_o.par_en  = regs_q.word[CW_PAR_BIT];
        cfg_o.val_sel = regs_q.word[CW_VAL_LSB +: 3];
    end

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.word & ~CW_WR_MASK) == 32'h0);

    // R8
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i < BASE_ADDR || addr_i > BASE_ADDR + ADDR_W'(CW_BYTES - 1)) |=> $stable(regs_q.word));

endmodule

// File: rtl/afx_pattern.sv
module afx_pattern
    import afx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic [2:0]          val_sel_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SAMPLE_W-1:0] field_o
);

    logic [SAMPLE_W-1:0] alt1, alt2;

    // Bit position j sits (SAMPLE_W-1-j) places below the MSB.
    for (genvar j = 0; j < SAMPLE_W; j++) begin : g_pat
        localparam int unsigned FROM_MSB = SAMPLE_W - 1 - j;
        assign alt1[j] = (FROM_MSB % 2) == 1;
        assign alt2[j] = ((FROM_MSB / 2) % 2) == 1;
    end

    always_comb begin
        unique case (val_sel_i)
            VAL_ZEROS: field_o = '0;
            VAL_ONES:  field_o = '1;
            VAL_ALT1:  field_o = alt1;
            VAL_ALT2:  field_o = alt2;
            default:   field_o = sample_i;
        endcase
    end

endmodule

// File: rtl/afx_frame_build.sv
module afx_frame_build
    import afx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16,
    localparam int unsigned FRAME_W = SAMPLE_W + OPT_BITS,
    localparam int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
    input  frame_cfg_t          cfg_i,
    input  logic [SAMPLE_W-1:0] field_i,
    input  logic [3:0]          dev_addr_i,
    input  logic [3:0]          range_i,
    input  logic                sup_hi_i,
    input  logic                sup_lo_i,
    input  logic                in_hi_i,
    input  logic                in_lo_i,
    output logic [FRAME_W-1:0]  frame_o,
    output logic [LEN_W-1:0]    len_o
);

    logic [FRAME_W-1:0] acc;
    logic [LEN_W-1:0]   n;
    logic               par_sample, par_frame;

    // Frame is kept right-aligned; each field shifts the earlier bits up.
    always_comb begin
        acc                 = '0;
        acc[SAMPLE_W-1:0]   = field_i;
        n                   = LEN_W'(SAMPLE_W);
        par_sample          = ^field_i;

        if (cfg_i.dev_inc) begin
            acc = {acc[FRAME_W-5:0], dev_addr_i};
            n   = n + LEN_W'(4);
        end
        if (cfg_i.sup_sel[0]) begin
            acc = {acc[FRAME_W-2:0], sup_hi_i};
            n   = n + LEN_W'(1);
        end
        if (cfg_i.sup_sel[1]) begin
            acc = {acc[FRAME_W-2:0], sup_lo_i};
            n   = n + LEN_W'(1);
        end
        if (cfg_i.in_sel[0]) begin
            acc = {acc[FRAME_W-2:0], in_hi_i};
            n   = n + LEN_W'(1);
        end
        if (cfg_i.in_sel[1]) begin
            acc = {acc[FRAME_W-2:0], in_lo_i};
            n   = n + LEN_W'(1);
        end
        if (cfg_i.rng_inc) begin
            acc = {acc[FRAME_W-5:0], range_i};
            n   = n + LEN_W'(4);
        end

        par_frame = ^acc;
        if (cfg_i.par_en) begin
            acc = {acc[FRAME_W-3:0], par_sample, par_frame};
            n   = n + LEN_W'(2);
        end

        frame_o = acc;
        len_o   = n;
    end

endmodule

// File: rtl/afx_shifter.sv
module afx_shifter #(
    parameter int unsigned FRAME_W = 30,
    parameter int unsigned MIN_LEN = 16,
    localparam int unsigned LEN_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               shift_en_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [LEN_W-1:0]   len_i,
    output logic               sdo_o,
    output logic               busy_o,
    output logic               done_o
);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic               sdo;
        logic [LEN_W-1:0]   rem;
        logic [FRAME_W-1:0] frame;
    } sh_state_t;

    sh_state_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.busy) begin
            sh_d.sdo = 1'b0;
            if (start_i) begin
                sh_d.busy  = 1'b1;
                sh_d.frame = frame_i;
                sh_d.rem   = len_i;
            end
        end else if (shift_en_i) begin
            if (sh_q.rem != '0) begin
                sh_d.sdo = sh_q.frame[sh_q.rem - LEN_W'(1)];
                sh_d.rem = sh_q.rem - LEN_W'(1);
            end else begin
                sh_d.busy = 1'b0;
                sh_d.sdo  = 1'b0;
                sh_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sdo_o  = sh_q.sdo;
    assign busy_o = sh_q.busy;
    assign done_o = sh_q.done;

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_q.busy |-> !sh_q.sdo);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.done |=> !sh_q.done);

    // R10
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_q.done) |-> $fell(sh_q.busy));

    // R9
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.busy |=> $stable(sh_q.frame));

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.busy && shift_en_i && sh_q.rem != '0) |=> sh_q.rem == $past(sh_q.rem) - LEN_W'(1));

    // R9
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_q.busy && start_i) |=> (sh_q.rem >= LEN_W'(MIN_LEN) && sh_q.rem <= LEN_W'(FRAME_W)));

endmodule

// File: rtl/adc_frame_tx.sv
module adc_frame_tx
    import afx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16,
    localparam int unsigned FRAME_W = SAMPLE_W + OPT_BITS,
    localparam int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [7:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [3:0]          dev_addr,
    input  logic [3:0]          range_code,
    input  logic                sup_hi_flag,
    input  logic                sup_lo_flag,
    input  logic                in_hi_flag,
    input  logic                in_lo_flag,
    input  logic                start,
    input  logic                shift_en,
    output logic                sdo,
    output logic                busy,
    output logic                done
);

    frame_cfg_t          cfg;
    logic [SAMPLE_W-1:0] field;
    logic [FRAME_W-1:0]  frame;
    logic [LEN_W-1:0]    len;

    afx_ctrl_regs #(
        .ADDR_W    (8),
        .BASE_ADDR (8'h10)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .cfg_o   (cfg)
    );

    afx_pattern #(.SAMPLE_W(SAMPLE_W)) u_pat (
        .val_sel_i (cfg.val_sel),
        .sample_i  (sample),
        .field_o   (field)
    );

    afx_frame_build #(.SAMPLE_W(SAMPLE_W)) u_build (
        .cfg_i      (cfg),
        .field_i    (field),
        .dev_addr_i (dev_addr),
        .range_i    (range_code),
        .sup_hi_i   (sup_hi_flag),
        .sup_lo_i   (sup_lo_flag),
        .in_hi_i    (in_hi_flag),
        .in_lo_i    (in_lo_flag),
        .frame_o    (frame),
        .len_o      (len)
    );

    afx_shifter #(
        .FRAME_W (FRAME_W),
        .MIN_LEN (SAMPLE_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .shift_en_i (shift_en),
        .frame_i    (frame),
        .len_i      (len),
        .sdo_o      (sdo),
        .busy_o     (busy),
        .done_o     (done)
    );

endmodule

// File: tb/adc_frame_tx_tb.sv
`timescale 1ns/1ps
module adc_frame_tx_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = 8'h00;
    logic [7:0]   reg_wdata = 8'h00;
    logic [7:0]   reg_rdata;
    logic [W-1:0] sample = '0;
    logic [3:0]   dev_addr = 4'h0;
    logic [3:0]   range_code = 4'h0;
    logic         sup_hi_flag = 1'b0, sup_lo_flag = 1'b0;
    logic         in_hi_flag = 1'b0, in_lo_flag = 1'b0;
    logic         start = 1'b0, shift_en = 1'b0;
    logic         sdo, busy, done;

    int errors = 0;
    int checks = 0;

    // Expected frame, MSB first
    bit eb [0:63];
    int elen;
    bit gb [0:63];

    // Configuration mirrored in the bench
    logic [2:0] c_sel;
    logic       c_par, c_dev, c_rng;
    logic [1:0] c_sup, c_in;

    always #10 clk = ~clk;

    adc_frame_tx #(.SAMPLE_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sample(sample),
        .dev_addr(dev_addr), .range_code(range_code),
        .sup_hi_flag(sup_hi_flag), .sup_lo_flag(sup_lo_flag),
        .in_hi_flag(in_hi_flag), .in_lo_flag(in_lo_flag),
        .start(start), .shift_en(shift_en), .sdo(sdo), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input bit b);
        eb[elen] = b;
        elen++;
    endtask

    // Reference frame from the requirements (R1..R7)
    task automatic build_ref();
        bit ps, pf, b;
        elen = 0;
        ps = 0;
        pf = 0;
        for (int k = 0; k < W; k++) begin
            case (c_sel)
                3'b100:  b = 0;
                3'b101:  b = 1;
                3'b110:  b = (k % 2) == 1;
                3'b111:  b = ((k / 2) % 2) == 1;
                default: b = sample[W-1-k];
            endcase
            ps ^= b;
            push(b);
        end
        if (c_dev) for (int k = 3; k >= 0; k--) push(dev_addr[k]);
        if (c_sup[0]) push(sup_hi_flag);
        if (c_sup[1]) push(sup_lo_flag);
        if (c_in[0]) push(in_hi_flag);
        if (c_in[1]) push(in_lo_flag);
        if (c_rng) for (int k = 3; k >= 0; k--) push(range_code[k]);
        for (int k = 0; k < elen; k++) pf ^= eb[k];
        if (c_par) begin
            push(ps);
            push(pf);
        end
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic apply_cfg();
        wr_byte(8'h10, {4'b0, c_par, c_sel});
        wr_byte(8'h11, {1'b0, c_dev, c_sup, c_in, 1'b0, c_rng});
    endtask

    // mid: 0 none, 1 register write mid-frame, 2 start pulse mid-frame
    task automatic run_frame(input string req, input bit gap, input int mid);
        bit same;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && sdo === 1'b0, "R10 busy after start", busy, 1);
        for (int i = 0; i < elen; i++) begin
            shift_en = 1'b1;
            if (i == 2 && mid == 1) begin
                reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 8'h05;
            end
            if (i == 2 && mid == 2) begin
                start = 1'b1; sample = ~sample;
            end
            @(negedge clk);
            reg_wr = 1'b0;
            start = 1'b0;
            gb[i] = sdo;
            if (gap) begin
                shift_en = 1'b0;
                @(negedge clk);
                chk(sdo === gb[i] && busy === 1'b1, "R10 hold between enables", sdo, gb[i]);
            end
        end
        same = 1;
        for (int i = 0; i < elen; i++) if (gb[i] !== eb[i]) same = 0;
        chk(same, req, 0, 1);
        if (!same) for (int i = 0; i < elen; i++)
            if (gb[i] !== eb[i]) $display("  bit %0d got %0b exp %0b", i, gb[i], eb[i]);
        shift_en = 1'b1;
        @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0 && sdo === 1'b0, "R10 frame end", {done, busy, sdo}, 3'b100);
        shift_en = 1'b0;
        @(negedge clk);
        chk(done === 1'b0 && sdo === 1'b0, "R10 done single pulse", {done, sdo}, 0);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    initial begin : watchdog
        #(20ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state, R10 idle
        chk(busy === 1'b0 && done === 1'b0 && sdo === 1'b0, "R10 idle after reset", {busy, done, sdo}, 0);
        for (int a = 8'h10; a <= 8'h13; a++) rd_chk(8'(a), 8'h00, "R8 reset value");

        // R8 reserved bits read zero
        for (int a = 8'h10; a <= 8'h13; a++) wr_byte(8'(a), 8'hFF);
        rd_chk(8'h10, 8'h0F, "R8 byte 10h mask");
        rd_chk(8'h11, 8'h7D, "R8 byte 11h mask");
        rd_chk(8'h12, 8'h00, "R8 byte 12h reserved");
        rd_chk(8'h13, 8'h00, "R8 byte 13h reserved");
        wr_byte(8'h14, 8'h00);
        wr_byte(8'h0F, 8'h00);
        rd_chk(8'h10, 8'h0F, "R8 foreign write ignored");
        rd_chk(8'h14, 8'h00, "R8 foreign read zero");

        // R1 R2 all select codes, parity on and off
        c_dev = 0; c_sup = 0; c_in = 0; c_rng = 0;
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 8; s++) begin
                c_sel = 3'(s); c_par = p[0];
                sample = 16'hA3C5 ^ 16'(s * 16'h1111);
                apply_cfg();
                build_ref();
                run_frame(s < 4 ? "R1 sample field" : "R2 test pattern", 0, 0);
            end
        end

        // R3 R4 R5 R6 R7 every optional field combination
        for (int m = 0; m < 128; m++) begin
            c_sel = 3'b000;
            c_dev = m[0]; c_sup = m[2:1]; c_in = m[4:3]; c_rng = m[5]; c_par = m[6];
            sample = 16'(m * 16'h3B7 + 16'h0F1);
            dev_addr = 4'(m + 5); range_code = 4'(m * 3 + 1);
            sup_hi_flag = m[1] ^ m[3]; sup_lo_flag = ~m[0];
            in_hi_flag = m[2]; in_lo_flag = m[4] ^ m[5];
            apply_cfg();
            build_ref();
            run_frame("R3 R4 R5 R6 R7 optional fields", 0, 0);
        end

        // R10 gapped enables, all fields on
        c_sel = 3'b010; c_dev = 1; c_sup = 2'b11; c_in = 2'b11; c_rng = 1; c_par = 1;
        sample = 16'h8001;
        apply_cfg();
        build_ref();
        run_frame("R10 gapped shift", 1, 0);

        // R9 register write during a frame affects only the next frame
        build_ref();
        run_frame("R9 frame fixed under write", 0, 1);
        c_sel = 3'b101; c_par = 0;
        build_ref();
        run_frame("R9 new config next frame", 0, 0);

        // R9 start while busy ignored
        c_sel = 3'b000;
        apply_cfg();
        sample = 16'h1234;
        build_ref();
        run_frame("R9 start while busy ignored", 0, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule